// File: doc/BRIEF.md
# ADC Result Frame Serializer with CRC-8 Check

This block forms the word an SPI analog-to-digital converter returns for each conversion and shifts it out, most significant bit first, while chip-select is low. The word carries a 16-bit raw result or a 20-bit averaged result. A 4-bit tag can follow the result: either the channel number or four status flags. When the CRC option is on, an 8-bit checksum goes into the word as well.

During the same chip-select window the block shifts in the host's word. With the CRC option on, it checks the host's trailing checksum byte against one it computes over the first 24 received bits. A mismatch rejects the frame and sets a sticky error flag.

All SPI pins are sampled in the system clock domain, and SCLK edges are detected there. At the falling edge of chip-select the block captures the result, the tag sources and the mode bits. Any change to them after that point takes effect only in the next frame.

Top module: `adc_frame_link`

## Requirements
- R1: A frame is 24 SCLK bits long when the latched CRC option is off and 32 bits when it is on. It applies to both directions. `frame_done` pulses for exactly one clock after the SCLK rising edge that carries the final bit.
- R2: The tag select code 2'b01 places `chan_id` right after the result. Code 2'b10 places `stat_flags` there. Codes 2'b00 and 2'b11 place four zero bits there.
- R3: With averaging off, the 24-bit payload is {result[15:0], tag[3:0], 4'b0}. With the CRC option off, the transmitted frame is that payload.
- R4: With averaging on, the 24-bit payload is {result[19:0], tag[3:0]}. With the CRC option off, the transmitted frame is that payload.
- R5: With the CRC option on, averaging off and tag code 00 or 11, the frame is {result[15:0], crc[7:0], 8'b0}. The checksum is computed over {result[15:0], 8'b0}.
- R6: In every other CRC-on case, the frame is {payload[23:0], crc[7:0]}. The checksum is CRC-8 with polynomial 0x07, initial value 0x00, processed MSB first over the 24 payload bits.
- R7: `rx_payload` presents the first 24 received bits when the frame completes. `frame_ok` goes high at completion unless the CRC option is on and the received last byte differs from the CRC-8 of those 24 bits. It goes low at the start of each frame.
- R8: A checksum mismatch gives a one-clock `crc_err` pulse together with `frame_done`, and sets `err_flag`. `err_flag` stays set until `err_clr`. A mismatch in the same clock as `err_clr` leaves the flag set.
- R9: The frame contents and mode bits are captured at the falling edge of `cs_n`. Input changes during the frame do not alter the bits shifted out.
- R10: If `cs_n` rises before the full frame length, the frame is aborted. There is no `frame_done`, no `crc_err`, `frame_ok` stays low and `err_flag` is unchanged.
- R11: After reset, `miso`, `frame_done`, `frame_ok`, `crc_err` and `err_flag` are 0. `miso` is 0 whenever chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI chip-select, active low |
| sclk | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | Host-to-device serial data |
| miso | output | 1 | Device-to-host serial data |
| conv_result | input | 20 | Conversion result (low 16 bits used without averaging) |
| chan_id | input | 4 | Channel number for the tag field |
| stat_flags | input | 4 | Status flags for the tag field |
| crc_en | input | 1 | CRC option for both directions |
| avg_on | input | 1 | Averaged 20-bit result in use |
| append_sel | input | 2 | Tag select code |
| err_clr | input | 1 | Clears the sticky error flag |
| rx_payload | output | 24 | First 24 bits received in the last complete frame |
| frame_done | output | 1 | One-clock pulse at frame completion |
| frame_ok | output | 1 | Last complete frame accepted |
| crc_err | output | 1 | One-clock pulse on checksum mismatch |
| err_flag | output | 1 | Sticky checksum error flag |

## Verification
A checksum mismatch at the end of a host frame and a clear request on `err_clr` can fall in the same clock. In that case the set must win. The bench raises `err_clr` at the same clock edge where it raises the final SCLK of a frame whose checksum it has deliberately corrupted, so the mismatch and the clear are both evaluated in one clock. It judges the outcome by `err_flag` still being high afterwards. A separate clear with no mismatch must then drop the flag.

// File: rtl/sfp_pkg.sv
// Shared widths, types and CRC-8 helpers for the ADC frame serializer.
// Assumes a CRC no wider than the payload and the tag/pad fields fitting
// beside the raw result inside the payload.
package sfp_pkg;
    parameter int RAW_W = 16;
    parameter int AVG_W = 20;
    parameter int TAG_W = 4;
    parameter int CRC_W = 8;
    parameter int PAY_W = AVG_W + TAG_W;
    parameter int FRM_W = PAY_W + CRC_W;
    parameter int PAD_W = PAY_W - RAW_W - TAG_W;
    parameter int TAIL_W = FRM_W - RAW_W - CRC_W;
    parameter int CNT_W = $clog2(FRM_W + 1);
    parameter logic [CRC_W-1:0] CRC_POLY = 8'h07;
    parameter logic [CRC_W-1:0] CRC_INIT = 8'h00;

    typedef enum logic [1:0] {
        APP_NONE     = 2'b00,
        APP_CHAN     = 2'b01,
        APP_STAT     = 2'b10,
        APP_NONE_ALT = 2'b11
    } app_sel_t;

    typedef struct packed {
        logic     crc_on;
        logic     avg;
        app_sel_t app;
    } frame_cfg_t;

    // One MSB-first CRC step for a single data bit.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    // CRC over a whole payload, MSB first, from the initial value.
    function automatic logic [CRC_W-1:0] crc_block(input logic [PAY_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = CRC_INIT;
        for (int i = PAY_W - 1; i >= 0; i--) begin
            c = crc_step(c, d[i]);
        end
        return c;
    endfunction
endpackage

// File: rtl/sfp_frame_builder.sv
// Combinational frame assembly: picks the tag, forms the 24-bit payload,
// computes its CRC and places it according to the mode bits.
// Assumes inputs already captured; output is left-aligned in FRM_W bits.
module sfp_frame_builder
    import sfp_pkg::*;
(
    input  logic [AVG_W-1:0] result,
    input  logic [TAG_W-1:0] chan,
    input  logic [TAG_W-1:0] flags,
    input  frame_cfg_t       cfg,
    output logic [FRM_W-1:0] frame
);
    logic [TAG_W-1:0] tag;
    logic [PAY_W-1:0] payload;
    logic [CRC_W-1:0] crc;
    logic             crc_mid;

    // Tag selection from the select code.
    always_comb begin
        unique case (cfg.app)
            APP_CHAN: tag = chan;
            APP_STAT: tag = flags;
            default:  tag = '0;
        endcase
    end

    // Payload shape depends on raw or averaged result width.
    always_comb begin
        if (cfg.avg) payload = {result, tag};
        else         payload = {result[RAW_W-1:0], tag, {PAD_W{1'b0}}};
    end

    assign crc     = crc_block(payload);
    assign crc_mid = !cfg.avg && (cfg.app == APP_NONE || cfg.app == APP_NONE_ALT);

    // Final placement of the checksum byte.
    always_comb begin
        if (!cfg.crc_on)  frame = {payload, {CRC_W{1'b0}}};
        else if (crc_mid) frame = {result[RAW_W-1:0], crc, {TAIL_W{1'b0}}};
        else              frame = {payload, crc};
    end
endmodule

// File: rtl/sfp_bit_ctrl.sv
// Chip-select and SCLK edge detection plus bit counter and mode latch.
// Assumes SPI pins are already synchronous to clk and SCLK idles low.
module sfp_bit_ctrl
    import sfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  frame_cfg_t       cfg_in,
    output frame_cfg_t       cfg_q,
    output logic             start,
    output logic             active,
    output logic             take,
    output logic             last,
    output logic             shift,
    output logic [CNT_W-1:0] bit_idx
);
    logic             cs_q;
    logic             sclk_q;
    logic [CNT_W-1:0] frame_len;
    logic             in_frame;

    assign start     = cs_q && !cs_n;
    assign frame_len = cfg_q.crc_on ? CNT_W'(FRM_W) : CNT_W'(PAY_W);
    assign in_frame  = active && !cs_n && (bit_idx < frame_len);
    assign take      = in_frame && sclk && !sclk_q;
    assign shift     = in_frame && !sclk && sclk_q;
    assign last      = take && (bit_idx == frame_len - 1'b1);

    // Previous-value registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    // Frame activity, bit count and mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            bit_idx <= '0;
            cfg_q   <= '0;
        end else if (start) begin
            active  <= 1'b1;
            bit_idx <= '0;
            cfg_q   <= cfg_in;
        end else if (cs_n) begin
            active  <= 1'b0;
        end else if (take) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/sfp_tx_shifter.sv
// Output shift register: loads the assembled frame at frame start and
// shifts left on each SCLK falling edge inside the frame.
// Assumes MSB is presented on miso from load until the first falling edge.
module sfp_tx_shifter
    import sfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             shift,
    input  logic             active,
    input  logic [FRM_W-1:0] frame,
    output logic             miso
);
    logic [FRM_W-1:0] sr;

    // Load on start, shift on falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (start) sr <= frame;
        else if (shift) sr <= {sr[FRM_W-2:0], 1'b0};
    end

    assign miso = active && sr[FRM_W-1];
endmodule

// File: rtl/sfp_rx_checker.sv
// Host frame receiver: collects payload and trailing CRC byte, runs the
// CRC bit-serially over the payload and judges the frame at its last bit.
// Assumes take/last come from the bit controller with a latched mode.
module sfp_rx_checker
    import sfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             take,
    input  logic             last,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             mosi,
    input  logic             crc_chk,
    input  logic             err_clr,
    output logic [PAY_W-1:0] rx_payload,
    output logic             frame_done,
    output logic             frame_ok,
    output logic             crc_err,
    output logic             err_flag
);
    logic [PAY_W-1:0] pay_sr;
    logic [PAY_W-1:0] pay_nx;
    logic [CRC_W-1:0] crc_run;
    logic [CRC_W-1:0] got_crc;
    logic [CRC_W-1:0] got_nx;
    logic             in_pay;
    logic             mismatch;

    assign in_pay   = bit_idx < CNT_W'(PAY_W);
    assign pay_nx   = {pay_sr[PAY_W-2:0], mosi};
    assign got_nx   = {got_crc[CRC_W-2:0], mosi};
    assign mismatch = crc_chk && last && (got_nx != crc_run);

    // Payload, running CRC and received CRC collection.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            pay_sr  <= '0;
            crc_run <= CRC_INIT;
            got_crc <= '0;
        end else if (take) begin
            if (in_pay) begin
                pay_sr  <= pay_nx;
                crc_run <= crc_step(crc_run, mosi);
            end else begin
                got_crc <= got_nx;
            end
        end
    end

    // Completion pulses, verdict and presented payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            crc_err    <= 1'b0;
            frame_ok   <= 1'b0;
            rx_payload <= '0;
        end else begin
            frame_done <= last;
            crc_err    <= mismatch;
            if (start) begin
                frame_ok <= 1'b0;
            end else if (last) begin
                frame_ok   <= !mismatch;
                rx_payload <= crc_chk ? pay_sr : pay_nx;
            end
        end
    end

    // Sticky error flag; a new mismatch outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_flag <= 1'b0;
        else if (mismatch) err_flag <= 1'b1;
        else if (err_clr)  err_flag <= 1'b0;
    end
endmodule

// File: rtl/adc_frame_link.sv
// Top level: SPI result serializer with optional CRC-8 in both directions.
// Assumes all SPI pins are synchronous to clk and SCLK edges are spaced
// at least two clk cycles apart.
module adc_frame_link
    import sfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             mosi,
    output logic             miso,
    input  logic [AVG_W-1:0] conv_result,
    input  logic [TAG_W-1:0] chan_id,
    input  logic [TAG_W-1:0] stat_flags,
    input  logic             crc_en,
    input  logic             avg_on,
    input  logic [1:0]       append_sel,
    input  logic             err_clr,
    output logic [PAY_W-1:0] rx_payload,
    output logic             frame_done,
    output logic             frame_ok,
    output logic             crc_err,
    output logic             err_flag
);
    frame_cfg_t       cfg_live;
    frame_cfg_t       cfg_q;
    logic             start;
    logic             active;
    logic             take;
    logic             last;
    logic             shift;
    logic [CNT_W-1:0] bit_idx;
    logic [FRM_W-1:0] frame;

    assign cfg_live = '{crc_on: crc_en, avg: avg_on, app: app_sel_t'(append_sel)};

    sfp_bit_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .cfg_in  (cfg_live),
        .cfg_q   (cfg_q),
        .start   (start),
        .active  (active),
        .take    (take),
        .last    (last),
        .shift   (shift),
        .bit_idx (bit_idx)
    );

    sfp_frame_builder u_build (
        .result (conv_result),
        .chan   (chan_id),
        .flags  (stat_flags),
        .cfg    (cfg_live),
        .frame  (frame)
    );

    sfp_tx_shifter u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .shift  (shift),
        .active (active),
        .frame  (frame),
        .miso   (miso)
    );

    sfp_rx_checker u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .take       (take),
        .last       (last),
        .bit_idx    (bit_idx),
        .mosi       (mosi),
        .crc_chk    (cfg_q.crc_on),
        .err_clr    (err_clr),
        .rx_payload (rx_payload),
        .frame_done (frame_done),
        .frame_ok   (frame_ok),
        .crc_err    (crc_err),
        .err_flag   (err_flag)
    );
endmodule

// File: rtl/sfp_link_checker.sv
// Assertion checker for adc_frame_link, attached by bind below.
module sfp_link_checker
    import sfp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       miso,
    input logic       frame_done,
    input logic       frame_ok,
    input logic       crc_err,
    input logic       err_flag,
    input logic       err_clr,
    input logic       start,
    input frame_cfg_t lat_cfg
);
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_err_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> err_flag);

    assert_err_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> (frame_done && !frame_ok));

    assert_nocrc_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !lat_cfg.crc_on) |-> frame_ok);

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(lat_cfg));

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> !frame_done);

    assert_miso_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !miso);
endmodule

bind adc_frame_link sfp_link_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .miso       (miso),
    .frame_done (frame_done),
    .frame_ok   (frame_ok),
    .crc_err    (crc_err),
    .err_flag   (err_flag),
    .err_clr    (err_clr),
    .start      (start),
    .lat_cfg    (cfg_q)
);

// File: tb/adc_frame_link_tb.sv
// Scoreboard bench: the driver pushes expected host-frame verdicts,
// the monitor pops them at each frame_done and compares.
module adc_frame_link_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic [19:0] conv_result = '0;
    logic [3:0]  chan_id = '0;
    logic [3:0]  stat_flags = '0;
    logic        crc_en = 1'b0;
    logic        avg_on = 1'b0;
    logic [1:0]  append_sel = 2'b00;
    logic        err_clr = 1'b0;
    logic [23:0] rx_payload;
    logic        frame_done;
    logic        frame_ok;
    logic        crc_err;
    logic        err_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [25:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_frame_link dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .conv_result(conv_result), .chan_id(chan_id),
        .stat_flags(stat_flags), .crc_en(crc_en), .avg_on(avg_on),
        .append_sel(append_sel), .err_clr(err_clr), .rx_payload(rx_payload),
        .frame_done(frame_done), .frame_ok(frame_ok), .crc_err(crc_err),
        .err_flag(err_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // CRC-8, poly 0x07, init 0, MSB first (R6).
    function automatic logic [7:0] ref_crc(input logic [23:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 23; i >= 0; i--) begin
            if (c[7] ^ d[i]) c = (c << 1) ^ 8'h07;
            else             c = c << 1;
        end
        return c;
    endfunction

    function automatic logic [31:0] ref_frame(input logic crc, input logic avg,
            input logic [1:0] sel, input logic [19:0] res, input logic [3:0] ch,
            input logic [3:0] fl);
        logic [3:0]  t;
        logic [23:0] p;
        t = (sel == 2'b01) ? ch : (sel == 2'b10) ? fl : 4'h0;
        p = avg ? {res, t} : {res[15:0], t, 4'h0};
        if (!crc) return {p, 8'h00};
        if (!avg && (sel == 2'b00 || sel == 2'b11)) return {res[15:0], ref_crc(p), 8'h00};
        return {p, ref_crc(p)};
    endfunction

    // Monitor: compare each completed host frame with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && crc_err && !frame_done) check("R8 crc_err without done", 32'(crc_err), 32'd0);
        if (rst_n && frame_done) begin
            if (exp_q.size() == 0) begin
                check("R1/R10 unexpected frame_done", 32'd1, 32'd0);
            end else begin
                logic [25:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " R7 rx_payload"}, 32'(rx_payload), 32'(e[25:2]));
                check({t, " R7 frame_ok"}, 32'(frame_ok), 32'(e[1]));
                check({t, " R8 crc_err"}, 32'(crc_err), 32'(e[0]));
            end
        end
    end

    task automatic xfer(input string tag, input logic crc, input logic avg,
            input logic [1:0] sel, input logic [19:0] res, input logic [3:0] ch,
            input logic [3:0] fl, input logic [23:0] hpay, input bit bad,
            input int abort_at, input bit clr_at_end, input bit change_mid);
        logic [31:0] expf;
        logic [31:0] host;
        logic [31:0] got;
        logic [31:0] mask;
        int len;
        int nbits;
        @(negedge clk);
        crc_en = crc; avg_on = avg; append_sel = sel;
        conv_result = res; chan_id = ch; stat_flags = fl;
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        len   = crc ? 32 : 24;
        nbits = (abort_at > 0) ? abort_at : len;
        expf  = ref_frame(crc, avg, sel, res, ch, fl);
        host  = crc ? {hpay, ref_crc(hpay) ^ {7'd0, bad}} : {hpay, 8'h00};
        mask  = crc ? 32'hFFFF_FFFF : 32'hFFFF_FF00;
        got   = '0;
        if (abort_at == 0) begin
            exp_q.push_back({hpay, !(crc && bad), crc && bad});
            tag_q.push_back(tag);
        end
        for (int i = 0; i < nbits; i++) begin
            got[31 - i] = miso;
            mosi = host[31 - i];
            sclk = 1'b1;
            if (clr_at_end && i == len - 1) err_clr = 1'b1;
            if (change_mid && i == 5) begin
                crc_en = ~crc; avg_on = ~avg; append_sel = ~sel;
                conv_result = ~res; chan_id = ~ch; stat_flags = ~fl;
            end
            @(negedge clk);
            err_clr = 1'b0;
            repeat (HALF - 1) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check({tag, " miso idle R11"}, 32'(miso), 32'd0);
        if (abort_at == 0) begin
            check({tag, " tx frame"}, got & mask, expf & mask);
            check({tag, " R1 all frames completed"}, 32'(exp_q.size()), 32'd0);
        end
    endtask

    task automatic pulse_clr;
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset miso", 32'(miso), 32'd0);
        check("R11 reset frame_done", 32'(frame_done), 32'd0);
        check("R11 reset frame_ok", 32'(frame_ok), 32'd0);
        check("R11 reset err_flag", 32'(err_flag), 32'd0);
        check("R11 reset crc_err", 32'(crc_err), 32'd0);

        // CRC off, raw result: R2 R3
        xfer("R3 raw none",   0, 0, 2'b00, 20'h0A5C3, 4'h9, 4'h6, 24'h123456, 0, 0, 0, 0);
        xfer("R2 raw chan",   0, 0, 2'b01, 20'h0A5C3, 4'h9, 4'h6, 24'hABCDEF, 0, 0, 0, 0);
        xfer("R2 raw flags",  0, 0, 2'b10, 20'h0A5C3, 4'h9, 4'h6, 24'h000001, 0, 0, 0, 0);
        xfer("R2 raw code11", 0, 0, 2'b11, 20'h0FFFF, 4'hF, 4'hF, 24'h800000, 0, 0, 0, 0);
        // CRC off, averaged result: R4
        xfer("R4 avg none",   0, 1, 2'b00, 20'h3B7E1, 4'h5, 4'hA, 24'h5A5A5A, 0, 0, 0, 0);
        xfer("R4 avg chan",   0, 1, 2'b01, 20'h3B7E1, 4'h5, 4'hA, 24'hC3C3C3, 0, 0, 0, 0);
        xfer("R4 avg flags",  0, 1, 2'b10, 20'hFFFFF, 4'h5, 4'hA, 24'h0F0F0F, 0, 0, 0, 0);
        // CRC off: a host byte is not checked (R7)
        xfer("R7 no check",   0, 0, 2'b01, 20'h01234, 4'h3, 4'h1, 24'hDEAD00, 1, 0, 0, 0);
        check("R8 no flag when CRC off", 32'(err_flag), 32'd0);

        // CRC on: middle position R5, last byte R6
        xfer("R5 mid none",   1, 0, 2'b00, 20'h0A5C3, 4'h9, 4'h6, 24'h123456, 0, 0, 0, 0);
        xfer("R5 mid code11", 1, 0, 2'b11, 20'h08001, 4'h9, 4'h6, 24'h654321, 0, 0, 0, 0);
        xfer("R6 raw chan",   1, 0, 2'b01, 20'h0BEEF, 4'hC, 4'h2, 24'hFACE00, 0, 0, 0, 0);
        xfer("R6 avg flags",  1, 1, 2'b10, 20'h3B7E1, 4'h1, 4'hD, 24'h00FF00, 0, 0, 0, 0);
        xfer("R6 avg code11", 1, 1, 2'b11, 20'h80001, 4'h1, 4'hD, 24'h777777, 0, 0, 0, 0);
        check("R7 good frames leave flag low", 32'(err_flag), 32'd0);

        // Mismatch and sticky flag: R8
        xfer("R8 bad crc",    1, 1, 2'b01, 20'h12345, 4'h7, 4'h0, 24'hA1B2C3, 1, 0, 0, 0);
        check("R8 flag set after mismatch", 32'(err_flag), 32'd1);
        check("R7 frame_ok low after mismatch", 32'(frame_ok), 32'd0);
        pulse_clr();
        check("R8 flag cleared", 32'(err_flag), 32'd0);
        xfer("R8 bad crc with clear", 1, 0, 2'b10, 20'h0C0DE, 4'h7, 4'h3, 24'h0BADF0, 1, 0, 1, 0);
        check("R8 set wins over clear", 32'(err_flag), 32'd1);
        pulse_clr();
        check("R8 flag cleared again", 32'(err_flag), 32'd0);

        // Mid-frame input changes ignored: R9
        xfer("R9 frozen inputs", 1, 1, 2'b01, 20'h2468A, 4'hB, 4'h4, 24'h13579B, 0, 0, 0, 1);
        check("R9 frame_ok after frozen frame", 32'(frame_ok), 32'd1);

        // Abort with a bad checksum queued: R10
        xfer("R10 abort", 1, 0, 2'b01, 20'h01111, 4'h2, 4'h2, 24'h222222, 1, 10, 0, 0);
        check("R10 frame_ok low after abort", 32'(frame_ok), 32'd0);
        check("R10 err_flag unchanged", 32'(err_flag), 32'd0);
        check("R10 no pending verdict", 32'(exp_q.size()), 32'd0);
        // A clean frame after the abort completes normally
        xfer("R10 frame after abort", 0, 1, 2'b10, 20'h99999, 4'h2, 4'h8, 24'h333333, 0, 0, 0, 0);
        check("R10 frame_ok after recovery", 32'(frame_ok), 32'd1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule